// File: doc/BRIEF.md
# Packetized Serial Transmitter

This block turns pairs of 16-bit words from a processor's register bus into 32-bit packets and sends them out one bit at a time on a single line. The processor writes the data word to one address and the tag word to the next. Once both halves have been written, the block moves the packet into a four-entry queue by itself. A separate send enable lets the serializer take the oldest queued packet and shift it out, one bit per baud tick. A status address reports whether the queue is full or empty and whether the serializer is busy.

A module enable freezes every register in the block. The surrounding chip can drop it whenever the transmitter is idle, and nothing is lost. A direction output starts high after reset and drops the first time the processor reaches any of the block's addresses.

Top module: `pkt_serial_tx`

## Requirements
- R1: After reset the line is high, `fifoEmpty` is 1, `fifoFull` is 0, `wordRdy` is 0, `dirRx` is 1 and `rdData` is 0.
- R2: A write strobe at address BASE_ADDR loads bits 15:0 of the staging packet, and one at BASE_ADDR+1 loads bits 31:16. A later write to the same half replaces the earlier value. A write to any other address changes nothing.
- R3: `wordRdy` is 1 only when both halves have been written since the last push. In the cycle after `wordRdy` is seen while the queue is not full, the packet enters the queue, `wordRdy` returns to 0 and `fifoEmpty` goes to 0.
- R4: The queue holds DEPTH (4) packets. `fifoFull` is 1 while it holds DEPTH packets. While the queue is full, the staged packet stays in place with `wordRdy` held at 1. It is pushed in the cycle after space frees.
- R5: A read strobe at BASE_ADDR+2 loads `rdData` on the next clock edge with status: bit 0 is full, bit 1 is empty, bit 2 is serializer busy, and all other bits are 0. Without such a read, `rdData` holds its value.
- R6: Serial output sends the packet least significant bit first. Bit 0 appears on the clock edge that loads the serializer, and each baud tick moves to the next bit. The line returns high after the 32nd tick and stays high while idle.
- R7: The serializer loads a packet only when `sendEn` is 1, the serializer is idle and the queue is not empty. Packets leave in the order in which they were pushed.
- R8: While `modEn` is 0, no register changes. Strobes, ticks and `sendEn` have no effect on the line, the flags, `rdData` or the staged packet.
- R9: `dirRx` falls to 0 on the first read or write strobe at one of the three block addresses, and stays at 0. Strobes at other addresses leave it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modEn | input | 1 | Module enable; when 0, all registers hold their values |
| baudTick | input | 1 | One-cycle pulse that advances the serializer by one bit |
| sfrAddr | input | 16 | Register bus address |
| wrStrobe | input | 1 | Write strobe |
| rdStrobe | input | 1 | Read strobe |
| wrData | input | 16 | Write data |
| sendEn | input | 1 | Permits the serializer to take the next queued packet |
| rdData | output | 16 | Registered status word |
| txLine | output | 1 | Serial output, high when idle |
| wordRdy | output | 1 | Both halves of the staging packet are filled |
| fifoFull | output | 1 | The queue holds DEPTH packets |
| fifoEmpty | output | 1 | The queue holds no packet |
| dirRx | output | 1 | Direction flag; cleared by the first access to a block address |

## Verification
The assertions assume that the processor does not write a half in the same cycle that the staged packet is pushed. The bench therefore writes only while `wordRdy` is 0 or the queue is full. The assertions also assume that `baudTick` is a single-cycle pulse and that the address is stable while a strobe is high. Every bench task raises a strobe or tick for exactly one clock and drops it right after the edge. A scripted sweep fills the queue, overflows it by one packet and then drains it. Each bit of every packet is compared with a packet value computed arithmetically in the bench. One packet also has its shift paused with `modEn` low.

// File: rtl/pst_pkg.sv
package pst_pkg;
  // Strobes issued by the control toward the datapath, one cycle each.
  typedef struct packed {
    logic ldLo;   // write lower half of staging packet
    logic ldHi;   // write upper half of staging packet
    logic push;   // move staging packet into queue
    logic load;   // move queue head into serializer
    logic shift;  // advance serializer by one bit
  } strobe_t;
endpackage

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              baudTick,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              sendEn,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              shBusy,
  output strobe_t           stb,
  output logic              wordRdy,
  output logic              dirRx,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(BASE_ADDR + 2);

  logic hitLo, hitHi, hitSt, rdStat, validAcc;
  logic loFilled, hiFilled;

  always_comb begin
    hitLo     = (sfrAddr == LO_ADDR);
    hitHi     = (sfrAddr == HI_ADDR);
    hitSt     = (sfrAddr == ST_ADDR);
    wordRdy   = loFilled & hiFilled;
    stb.ldLo  = modEn & wrStrobe & hitLo;
    stb.ldHi  = modEn & wrStrobe & hitHi;
    stb.push  = modEn & wordRdy & ~fifoFull;
    stb.load  = modEn & sendEn & ~shBusy & ~fifoEmpty;
    stb.shift = modEn & baudTick & shBusy;
    rdStat    = modEn & rdStrobe & hitSt;
    validAcc  = modEn & (wrStrobe | rdStrobe) & (hitLo | hitHi | hitSt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loFilled <= 1'b0;
      hiFilled <= 1'b0;
      dirRx    <= 1'b1;
      rdData   <= '0;
    end else begin
      if (stb.ldLo)      loFilled <= 1'b1;
      else if (stb.push) loFilled <= 1'b0;
      if (stb.ldHi)      hiFilled <= 1'b1;
      else if (stb.push) hiFilled <= 1'b0;
      if (validAcc)      dirRx    <= 1'b0;
      if (rdStat)        rdData   <= DATA_W'({shBusy, fifoEmpty, fifoFull});
    end
  end

  // R3: a push with no simultaneous write leaves the staging buffer empty
  p_push_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !stb.ldLo && !stb.ldHi) |=> !wordRdy);
  // R8: a disabled module keeps its control state
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> ($stable(wordRdy) && $stable(dirRx) && $stable(rdData)));
  // R5: status word only changes after a read strobe
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));
  // R9: direction flag only falls after an enabled strobe
  p_dir_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirRx) |-> $past(modEn && (wrStrobe || rdStrobe)));
endmodule

// File: rtl/pst_dpath.sv
module pst_dpath
  import pst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              shBusy,
  output logic              txLine
);
  localparam int PKT_W = 2 * DATA_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BIT_W = $clog2(PKT_W);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(PKT_W - 1);

  logic [PKT_W-1:0] stage;
  logic [PKT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [PKT_W-1:0] shReg;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       ldHalf;

  assign ldHalf = {stb.ldHi, stb.ldLo};

  // Staging packet: one register per half, each with its own load strobe
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN)          stage[h*DATA_W +: DATA_W] <= '0;
      else if (ldHalf[h]) stage[h*DATA_W +: DATA_W] <= wrData;
    end
  end

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign txLine    = shBusy ? shReg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= stage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (stb.load) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({stb.push, stb.load})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      shBusy <= 1'b0;
    end else if (stb.load) begin
      shReg  <= mem[rdPtr];
      bitCnt <= '0;
      shBusy <= 1'b1;
    end else if (stb.shift) begin
      shReg  <= shReg >> 1;
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) shBusy <= 1'b0;
    end
  end

  // R4: never push into a full queue, occupancy stays bounded
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !fifoFull);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R7: never pop an empty queue or reload a busy serializer
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> (!fifoEmpty && !shBusy));
  // R6: shifting only happens on a loaded serializer; busy only starts from a load
  p_shift_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |-> shBusy);
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shBusy) |-> $past(stb.load));
endmodule

// File: rtl/pkt_serial_tx.sv
module pkt_serial_tx
  import pst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 4,
  parameter int BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              baudTick,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sendEn,
  output logic [DATA_W-1:0] rdData,
  output logic              txLine,
  output logic              wordRdy,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              dirRx
);
  strobe_t stb;
  logic    shBusy;

  pst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .baudTick(baudTick),
    .sfrAddr(sfrAddr), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .sendEn(sendEn), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .shBusy(shBusy), .stb(stb), .wordRdy(wordRdy), .dirRx(dirRx),
    .rdData(rdData)
  );

  pst_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .shBusy(shBusy),
    .txLine(txLine)
  );
endmodule

// File: tb/tb_pkt_serial_tx.sv
module tb_pkt_serial_tx;
  localparam logic [15:0] BASE = 16'h0040;

  logic        clk = 1'b0;
  logic        rstN, modEn, baudTick, wrStrobe, rdStrobe, sendEn;
  logic [15:0] sfrAddr, wrData, rdData;
  logic        txLine, wordRdy, fifoFull, fifoEmpty, dirRx;
  int          nChk = 0, nFail = 0;
  bit          done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pkt_serial_tx dut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .baudTick(baudTick),
    .sfrAddr(sfrAddr), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .wrData(wrData), .sendEn(sendEn), .rdData(rdData), .txLine(txLine),
    .wordRdy(wordRdy), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .dirRx(dirRx)
  );

  function automatic logic [31:0] expPkt(int k);
    return {16'(32'hA5C0 + k), 16'(32'h1234 + k * 32'h1111)};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    sfrAddr = a; wrData = d; wrStrobe = 1'b1;
    cyc();
    wrStrobe = 1'b0;
  endtask

  task automatic rd(logic [15:0] a);
    sfrAddr = a; rdStrobe = 1'b1;
    cyc();
    rdStrobe = 1'b0;
  endtask

  task automatic startSend();
    sendEn = 1'b1;
    cyc();
    sendEn = 1'b0;
  endtask

  task automatic shiftOut(logic [31:0] p, bit pause);
    for (int b = 0; b < 32; b++) begin
      chk($sformatf("R6 bit %0d", b), 32'(txLine), 32'(p[b]));
      if (pause && b == 10) begin
        modEn = 1'b0; baudTick = 1'b1;
        cyc(); cyc();
        chk("R8 shift held", 32'(txLine), 32'(p[b]));
        modEn = 1'b1; baudTick = 1'b0;
      end
      baudTick = 1'b1;
      cyc();
      baudTick = 1'b0;
      cyc(); cyc();
    end
    chk("R6 idle high after packet", 32'(txLine), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; modEn = 1'b1; baudTick = 1'b0; wrStrobe = 1'b0;
    rdStrobe = 1'b0; sendEn = 1'b0; sfrAddr = '0; wrData = '0;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 txLine", 32'(txLine), 32'd1);
    chk("R1 fifoEmpty", 32'(fifoEmpty), 32'd1);
    chk("R1 fifoFull", 32'(fifoFull), 32'd0);
    chk("R1 wordRdy", 32'(wordRdy), 32'd0);
    chk("R1 dirRx", 32'(dirRx), 32'd1);
    chk("R1 rdData", 32'(rdData), 32'd0);

    // R2/R9: foreign addresses are ignored
    wr(BASE + 16'd5, 16'hFFFF);
    wr(BASE + 16'd3, 16'hFFFF);
    rd(BASE + 16'd7);
    chk("R2 foreign write no wordRdy", 32'(wordRdy), 32'd0);
    chk("R2 foreign write queue empty", 32'(fifoEmpty), 32'd1);
    chk("R9 foreign access keeps dirRx", 32'(dirRx), 32'd1);
    chk("R2 foreign read keeps rdData", 32'(rdData), 32'd0);

    // R2/R3/R9: lower half alone, then overwritten
    wr(BASE, 16'hBEEF);
    chk("R9 dirRx falls", 32'(dirRx), 32'd0);
    chk("R3 lower only no wordRdy", 32'(wordRdy), 32'd0);

    // Fill the queue: packet 0 lower first, the rest upper first
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p;
      p = expPkt(k);
      if (k == 0) begin
        wr(BASE, p[15:0]);
        chk("R3 lower overwritten no wordRdy", 32'(wordRdy), 32'd0);
        wr(BASE + 16'd1, p[31:16]);
      end else begin
        wr(BASE + 16'd1, p[31:16]);
        chk("R3 upper only no wordRdy", 32'(wordRdy), 32'd0);
        wr(BASE, p[15:0]);
      end
      chk("R3 both halves wordRdy", 32'(wordRdy), 32'd1);
      cyc();
      chk("R3 push clears wordRdy", 32'(wordRdy), 32'd0);
      chk("R3 queue not empty", 32'(fifoEmpty), 32'd0);
      chk($sformatf("R4 full after %0d pushes", k + 1), 32'(fifoFull), 32'(k == 3));
    end
    chk("R9 dirRx stays low", 32'(dirRx), 32'd0);
    rd(BASE + 16'd2);
    chk("R5 status full", 32'(rdData), 32'h0001);

    // R4: fifth packet waits while full
    wr(BASE, expPkt(4)[15:0]);
    wr(BASE + 16'd1, expPkt(4)[31:16]);
    cyc(); cyc(); cyc();
    chk("R4 staged packet waits", 32'(wordRdy), 32'd1);
    chk("R4 still full", 32'(fifoFull), 32'd1);

    // R8: disabled module ignores everything
    modEn = 1'b0; sendEn = 1'b1;
    wr(BASE, 16'hDEAD);
    rd(BASE + 16'd2);
    cyc(); cyc();
    chk("R8 line idle", 32'(txLine), 32'd1);
    chk("R8 full held", 32'(fifoFull), 32'd1);
    chk("R8 wordRdy held", 32'(wordRdy), 32'd1);
    chk("R8 rdData held", 32'(rdData), 32'h0001);
    sendEn = 1'b0; modEn = 1'b1;
    cyc();
    chk("R7 no load without sendEn", 32'(txLine), 32'd1);

    // R4/R7: load frees a slot, the staged packet follows one cycle later
    startSend();
    chk("R4 slot freed", 32'(fifoFull), 32'd0);
    chk("R4 wordRdy until push", 32'(wordRdy), 32'd1);
    cyc();
    chk("R4 delayed push full", 32'(fifoFull), 32'd1);
    chk("R4 delayed push clears wordRdy", 32'(wordRdy), 32'd0);
    rd(BASE + 16'd2);
    chk("R5 status full busy", 32'(rdData), 32'h0005);
    shiftOut(expPkt(0), 1'b1);

    // R6/R7: drain in order, line idles between packets
    for (int k = 1; k < 5; k++) begin
      startSend();
      shiftOut(expPkt(k), 1'b0);
      cyc(); cyc(); cyc();
      chk("R7 idle without sendEn", 32'(txLine), 32'd1);
    end
    chk("R7 queue drained", 32'(fifoEmpty), 32'd1);
    rd(BASE + 16'd2);
    chk("R5 status empty idle", 32'(rdData), 32'h0002);

    // R7: sendEn with an empty queue does nothing
    sendEn = 1'b1;
    cyc(); cyc(); cyc();
    sendEn = 1'b0;
    chk("R7 empty queue no start", 32'(txLine), 32'd1);
    rd(BASE + 16'd2);
    chk("R7 not busy", 32'(rdData), 32'h0002);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule